// File: doc/BRIEF.md
# Serial Link Transaction Sequencer

This block runs one whole transaction on a two-wire serial management link. A separate encoder shifts the command bits out, and a separate receiver collects the slave's reply. The sequencer sits above both. It starts the command, clocks the echo gap, and asks the receiver for the reply. It then acts on the reply tag. A busy slave is polled again after a run of idle clocks. A slave that stays busy is ended with a terminate command. At the end of every transaction the slave is primed with idle clocks.

The sequencer also performs a link-reset break and a power-up flush. It drives the line clock itself during all idle, echo and break phases: `line_tick` means one bit clock in that cycle, with the data level on `line_data`. The caller sees a ready/valid request port and a one-cycle done pulse that carries a 3-bit status.

Top module: `xact_sequencer`

## Requirements
- R1: After reset the block issues INIT_CLKS consecutive ticks with data high while `req_ready` is low, and then raises `req_ready`.
- R2: A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` stays low until the done pulse, requests made meanwhile have no effect, and `done` is high for exactly one cycle.
- R3: A read, write or terminate request (op 0, 1, 2) pulses `enc_go` with `enc_kind` equal to the op. After `enc_done` it issues ECHO_CLKS ticks with data high and then pulses `rx_go`.
- R4: Reply tags are 0 acknowledge, 1 busy, 2 general error and 3 checksum-rejected error. An acknowledge with no fault ends the transaction with status 0.
- R5: A busy tag causes POLL_IDLE_CLKS ticks with data high, then `enc_go` with `enc_kind` 3 (poll), the echo ticks and a new `rx_go`. A POLL_IDLE_CLKS value below 21 is rejected at elaboration.
- R6: Once MAX_BUSY polls have been sent, the next busy tag still causes the idle ticks, followed by `enc_kind` 2 (terminate), the echo ticks and one more reply. The status is then 1, whatever that reply is.
- R7: Tag 2 ends the transaction with status 2, and tag 3 ends it with status 3.
- R8: `rx_fault` 1 (no start bit in time) gives status 4, and `rx_fault` 2 or 3 (bad checksum) gives status 5. A nonzero fault takes priority over the tag.
- R9: Every read, write or terminate transaction ends with PRIME_CLKS ticks with data high, and `done` follows in the next cycle.
- R10: A break request (op 3) issues BRK_PRE_CLKS ticks high, then BRK_LOW_CLKS ticks low, then ECHO_CLKS plus BRK_POST_CLKS ticks high, and then `done` with status 0. It makes no encoder or receiver requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 read, 1 write, 2 terminate, 3 break |
| req_ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | Result code, valid with done |
| line_tick | output | 1 | One line clock is issued this cycle |
| line_data | output | 1 | Data level for the tick |
| enc_go | output | 1 | Start the command encoder |
| enc_kind | output | 2 | Command to encode: op code, or 3 for poll |
| enc_done | input | 1 | Encoder finished shifting |
| rx_go | output | 1 | Start the reply receiver |
| rx_rd | output | 1 | Reply carries read data |
| rx_done | input | 1 | Reply complete; tag and fault valid |
| rx_tag | input | 2 | Reply tag |
| rx_fault | input | 2 | 0 none, 1 timeout, 2 or 3 checksum |

## Verification
The outputs are registered. Each tick, encoder start, receiver start and done therefore appears one cycle after the edge that moved the state. A phase of N ticks lasts exactly N cycles, and the cycle after the last tick carries the next event. The bench samples at the falling edge and turns the output stream into an ordered log of tick runs and events, which it compares with a log built from the requirements. As a result, every count and every ordering is checked exactly, without guessing at latency. The bench's encoder and receiver models answer after a fixed delay. The done pulse is checked again on the following falling edge to confirm that it lasted only one cycle.

// File: rtl/xseq_pkg.sv
package xseq_pkg;

    localparam logic [1:0] OP_READ   = 2'd0;
    localparam logic [1:0] OP_WRITE  = 2'd1;
    localparam logic [1:0] OP_TERM   = 2'd2;
    localparam logic [1:0] OP_BREAK  = 2'd3;
    localparam logic [1:0] KIND_POLL = 2'd3;

    localparam logic [1:0] TAG_ACK   = 2'd0;
    localparam logic [1:0] TAG_BUSY  = 2'd1;
    localparam logic [1:0] TAG_GERR  = 2'd2;

    localparam logic [1:0] FLT_NONE  = 2'd0;
    localparam logic [1:0] FLT_TMO   = 2'd1;

    localparam logic [2:0] ST_OK     = 3'd0;
    localparam logic [2:0] ST_STUCK  = 3'd1;
    localparam logic [2:0] ST_GERR   = 3'd2;
    localparam logic [2:0] ST_CERR   = 3'd3;
    localparam logic [2:0] ST_TMO    = 3'd4;
    localparam logic [2:0] ST_CRC    = 3'd5;

    typedef enum logic [3:0] {
        PH_INIT, PH_IDLE, PH_SEND, PH_ECHO, PH_RECV, PH_GAP, PH_PRIME,
        PH_BPRE, PH_BLOW, PH_BECHO, PH_BPOST, PH_FIN
    } phase_e;

    typedef struct packed {
        phase_e     ph;
        logic [1:0] op;
        logic [1:0] kind;
        logic       escal;
        logic       go;
        logic       rxgo;
        logic [2:0] stat;
    } seq_s;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/xseq_span_ctr.sv
module xseq_span_ctr #(
    parameter int            CW      = 8,
    parameter logic [CW-1:0] RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          fin
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)              cnt_d = load_val;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
        else                   cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= RST_VAL;
        else        cnt_q <= cnt_d;
    end

    assign fin = (cnt_q == CW'(1));
endmodule

// File: rtl/xseq_retry_ctr.sv
module xseq_retry_ctr #(
    parameter int MAX_BUSY = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic exhausted
);
    localparam int RW = $clog2(MAX_BUSY + 1);
    logic [RW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + 1'b1;
        else          cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign exhausted = (cnt_q == RW'(MAX_BUSY));
endmodule

// File: rtl/xact_sequencer.sv
module xact_sequencer
    import xseq_pkg::*;
#(
    parameter int INIT_CLKS      = 5000,
    parameter int PRIME_CLKS     = 100,
    parameter int POLL_IDLE_CLKS = 100,
    parameter int MAX_BUSY       = 100,
    parameter int ECHO_CLKS      = 16,
    parameter int BRK_PRE_CLKS   = 50,
    parameter int BRK_LOW_CLKS   = 256,
    parameter int BRK_POST_CLKS  = 16000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_op,
    output logic       req_ready,
    output logic       done,
    output logic [2:0] status,
    output logic       line_tick,
    output logic       line_data,
    output logic       enc_go,
    output logic [1:0] enc_kind,
    input  logic       enc_done,
    output logic       rx_go,
    output logic       rx_rd,
    input  logic       rx_done,
    input  logic [1:0] rx_tag,
    input  logic [1:0] rx_fault
);
    localparam int MAXC = imax(imax(imax(INIT_CLKS, PRIME_CLKS), imax(POLL_IDLE_CLKS, ECHO_CLKS)),
                               imax(imax(BRK_PRE_CLKS, BRK_LOW_CLKS), BRK_POST_CLKS));
    localparam int CW = $clog2(MAXC + 1);

    if (POLL_IDLE_CLKS < 21) begin : g_poll_gap_too_short
        $error("POLL_IDLE_CLKS must be at least 21");
    end

    seq_s          s_d, s_q;
    logic          ld;
    logic [CW-1:0] ldv;
    logic          fin;
    logic          bclr, binc, exhausted;

    xseq_span_ctr #(.CW(CW), .RST_VAL(CW'(INIT_CLKS))) u_span (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ldv), .fin(fin)
    );

    xseq_retry_ctr #(.MAX_BUSY(MAX_BUSY)) u_retry (
        .clk(clk), .rst_n(rst_n), .clr(bclr), .inc(binc), .exhausted(exhausted)
    );

    always_comb begin
        s_d      = s_q;
        s_d.go   = 1'b0;
        s_d.rxgo = 1'b0;
        ld       = 1'b0;
        ldv      = '0;
        bclr     = 1'b0;
        binc     = 1'b0;
        unique case (s_q.ph)
            PH_INIT: if (fin) s_d.ph = PH_IDLE;
            PH_IDLE: if (req_valid) begin
                s_d.op    = req_op;
                s_d.escal = 1'b0;
                bclr      = 1'b1;
                if (req_op == OP_BREAK) begin
                    s_d.ph = PH_BPRE;
                    ld     = 1'b1;
                    ldv    = CW'(BRK_PRE_CLKS);
                end else begin
                    s_d.ph   = PH_SEND;
                    s_d.go   = 1'b1;
                    s_d.kind = req_op;
                end
            end
            PH_SEND: if (enc_done) begin
                s_d.ph = PH_ECHO;
                ld     = 1'b1;
                ldv    = CW'(ECHO_CLKS);
            end
            PH_ECHO: if (fin) begin
                s_d.ph   = PH_RECV;
                s_d.rxgo = 1'b1;
            end
            PH_RECV: if (rx_done) begin
                s_d.ph = PH_PRIME;
                ld     = 1'b1;
                ldv    = CW'(PRIME_CLKS);
                if (s_q.escal)                s_d.stat = ST_STUCK;
                else if (rx_fault == FLT_TMO) s_d.stat = ST_TMO;
                else if (rx_fault != FLT_NONE) s_d.stat = ST_CRC;
                else if (rx_tag == TAG_ACK)   s_d.stat = ST_OK;
                else if (rx_tag == TAG_GERR)  s_d.stat = ST_GERR;
                else if (rx_tag == TAG_BUSY) begin
                    s_d.ph = PH_GAP;
                    ldv    = CW'(POLL_IDLE_CLKS);
                end else                      s_d.stat = ST_CERR;
            end
            PH_GAP: if (fin) begin
                s_d.ph = PH_SEND;
                s_d.go = 1'b1;
                if (exhausted) begin
                    s_d.escal = 1'b1;
                    s_d.kind  = OP_TERM;
                end else begin
                    s_d.kind = KIND_POLL;
                    binc     = 1'b1;
                end
            end
            PH_PRIME: if (fin) s_d.ph = PH_FIN;
            PH_BPRE: if (fin) begin
                s_d.ph = PH_BLOW;
                ld     = 1'b1;
                ldv    = CW'(BRK_LOW_CLKS);
            end
            PH_BLOW: if (fin) begin
                s_d.ph = PH_BECHO;
                ld     = 1'b1;
                ldv    = CW'(ECHO_CLKS);
            end
            PH_BECHO: if (fin) begin
                s_d.ph = PH_BPOST;
                ld     = 1'b1;
                ldv    = CW'(BRK_POST_CLKS);
            end
            PH_BPOST: if (fin) begin
                s_d.ph   = PH_FIN;
                s_d.stat = ST_OK;
            end
            PH_FIN:  s_d.ph = PH_IDLE;
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.ph    <= PH_INIT;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready = (s_q.ph == PH_IDLE);
    assign done      = (s_q.ph == PH_FIN);
    assign status    = s_q.stat;
    assign line_tick = (s_q.ph == PH_INIT) || (s_q.ph == PH_ECHO) || (s_q.ph == PH_GAP) ||
                       (s_q.ph == PH_PRIME) || (s_q.ph == PH_BPRE) || (s_q.ph == PH_BLOW) ||
                       (s_q.ph == PH_BECHO) || (s_q.ph == PH_BPOST);
    assign line_data = (s_q.ph != PH_BLOW);
    assign enc_go    = s_q.go;
    assign enc_kind  = s_q.kind;
    assign rx_go     = s_q.rxgo;
    assign rx_rd     = (s_q.op == OP_READ) && !s_q.escal;
endmodule

// File: rtl/xact_sequencer_chk.sv
module xact_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       done,
    input logic [2:0] status,
    input logic       line_tick,
    input logic       line_data,
    input logic       enc_go,
    input logic       rx_go
);
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_accept_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_ready_vs_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && req_ready));

    p_one_action_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({enc_go, rx_go, line_tick}));

    p_tick_before_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(line_tick) && $past(line_data)));

    p_status_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status <= 3'd5));

    p_low_only_ticking_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !line_data |-> (line_tick && !req_ready));
endmodule

bind xact_sequencer xact_sequencer_chk chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .done(done), .status(status), .line_tick(line_tick), .line_data(line_data),
    .enc_go(enc_go), .rx_go(rx_go)
);

// File: tb/xact_sequencer_tb_top.sv
module xact_sequencer_tb_top;
    localparam int INIT = 20, PRIME = 6, POLL = 24, MAXB = 3, ECHO = 4;
    localparam int PRE = 5, LOW = 7, POST = 9;
    localparam int K = 100000;

    logic clk = 1'b0, rst_n = 1'b0;
    always #10 clk = ~clk;

    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic       req_ready, done, line_tick, line_data, enc_go, rx_go, rx_rd;
    logic [2:0] status;
    logic [1:0] enc_kind;
    logic       enc_done = 1'b0, rx_done = 1'b0;
    logic [1:0] rx_tag = 2'd0, rx_fault = 2'd0;

    xact_sequencer #(
        .INIT_CLKS(INIT), .PRIME_CLKS(PRIME), .POLL_IDLE_CLKS(POLL), .MAX_BUSY(MAXB),
        .ECHO_CLKS(ECHO), .BRK_PRE_CLKS(PRE), .BRK_LOW_CLKS(LOW), .BRK_POST_CLKS(POST)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_ready(req_ready), .done(done), .status(status),
        .line_tick(line_tick), .line_data(line_data), .enc_go(enc_go),
        .enc_kind(enc_kind), .enc_done(enc_done), .rx_go(rx_go), .rx_rd(rx_rd),
        .rx_done(rx_done), .rx_tag(rx_tag), .rx_fault(rx_fault)
    );

    int checks = 0, errors = 0, cyc = 0;
    int act[4096];
    int act_n = 0;
    int expv[4096];
    int exp_n = 0;
    int run_lvl = 1, run_len = 0;
    int rq_tag[2048];
    int rq_flt[2048];
    int rq_wr = 0, rq_rd = 0;
    int e_cnt = 0, r_cnt = 0;

    task automatic check(input bit ok, input string req, input int a, input int e);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, a, e);
        end
    endtask

    function automatic void flush_run();
        if (run_len > 0) begin
            act[act_n] = (run_lvl != 0) ? run_len : K + run_len;
            act_n++;
            run_len = 0;
        end
    endfunction

    // Event log built from the ports
    always @(negedge clk) if (rst_n) begin
        if (line_tick) begin
            if (run_len > 0 && run_lvl != int'(line_data)) flush_run();
            run_lvl = int'(line_data);
            run_len++;
        end
        if (enc_go) begin flush_run(); act[act_n] = 2*K + int'(enc_kind); act_n++; end
        if (rx_go)  begin flush_run(); act[act_n] = 3*K; act_n++; end
        if (done)   begin flush_run(); act[act_n] = 4*K + int'(status); act_n++; end
    end

    // Encoder and receiver models
    always @(negedge clk) begin
        enc_done = 1'b0;
        rx_done  = 1'b0;
        if (e_cnt > 0) begin
            e_cnt--;
            if (e_cnt == 0) enc_done = 1'b1;
        end
        if (r_cnt > 0) begin
            r_cnt--;
            if (r_cnt == 0) begin
                rx_done  = 1'b1;
                rx_tag   = 2'(rq_tag[rq_rd]);
                rx_fault = 2'(rq_flt[rq_rd]);
                rq_rd++;
            end
        end
        if (rst_n && enc_go) e_cnt = 3;
        if (rst_n && rx_go)  r_cnt = 2;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic void epush(input int v);
        expv[exp_n] = v;
        exp_n++;
    endfunction

    function automatic void add_resp(input int tag, input int flt);
        rq_tag[rq_wr] = tag;
        rq_flt[rq_wr] = flt;
        rq_wr++;
    endfunction

    // Expected log from the requirements
    function automatic string build_exp(input int op);
        int    m = rq_rd, busy = 0, st = 0, t, f;
        bit    fin = 0;
        string lab = "R3 R9";
        if (op == 3) begin
            epush(PRE); epush(K + LOW); epush(ECHO + POST); epush(4*K);
            return "R10";
        end
        epush(2*K + op); epush(ECHO); epush(3*K);
        while (!fin) begin
            t = rq_tag[m]; f = rq_flt[m]; m++;
            fin = 1;
            if (f == 1)      begin st = 4; lab = {lab, " R8"}; end
            else if (f != 0) begin st = 5; lab = {lab, " R8"}; end
            else if (t == 0) begin st = 0; lab = {lab, " R4"}; end
            else if (t == 2) begin st = 2; lab = {lab, " R7"}; end
            else if (t == 3) begin st = 3; lab = {lab, " R7"}; end
            else begin
                epush(POLL);
                if (busy < MAXB) begin
                    busy++;
                    epush(2*K + 3); epush(ECHO); epush(3*K);
                    lab = {lab, " R5"};
                    fin = 0;
                end else begin
                    epush(2*K + 2); epush(ECHO); epush(3*K);
                    m++;
                    st = 1;
                    lab = {lab, " R6"};
                end
            end
        end
        epush(PRIME); epush(4*K + st);
        return lab;
    endfunction

    task automatic run_xact(input int op, input bit poke);
        string lab;
        lab = build_exp(op);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_op    = 2'(op);
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R2 ready low after accept", int'(req_ready), 0);
        if (poke) begin
            for (int i = 0; i < 3; i++) begin
                req_valid = 1'b1;
                req_op    = 2'd3;
                @(negedge clk);
                check(!req_ready, "R2 ready low while busy", int'(req_ready), 0);
            end
            req_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        check(!done, "R2 done lasts one cycle", int'(done), 0);
        check(act_n == exp_n, {lab, " event count"}, act_n, exp_n);
        for (int i = 0; i < exp_n; i++) begin
            if (i < act_n) check(act[i] == expv[i], lab, act[i], expv[i]);
        end
        act_n = 0;
        exp_n = 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!req_ready, "R1 ready low after reset", int'(req_ready), 0);
        check(line_tick && line_data, "R1 flush tick high", int'({line_tick, line_data}), 3);
        check(!done, "R1 no done after reset", int'(done), 0);
        while (!req_ready) @(negedge clk);
        check(run_len == INIT && run_lvl == 1 && act_n == 0, "R1 flush length", run_len, INIT);
        run_len = 0;

        add_resp(0, 0);                 run_xact(0, 0);
        add_resp(0, 0);                 run_xact(1, 1);
        add_resp(2, 0);                 run_xact(2, 0);
        add_resp(3, 0);                 run_xact(0, 0);
        add_resp(0, 1);                 run_xact(0, 0);
        add_resp(1, 2);                 run_xact(1, 0);
        add_resp(1, 0); add_resp(1, 0); add_resp(0, 0); run_xact(0, 0);
        for (int i = 0; i <= MAXB; i++) add_resp(1, 0);
        add_resp(0, 0);                 run_xact(0, 0);
        for (int i = 0; i <= MAXB; i++) add_resp(1, 0);
        add_resp(2, 0);                 run_xact(1, 1);
        run_xact(3, 0);
        run_xact(3, 1);

        for (int n = 0; n < 30; n++) begin
            int op, b, r;
            op = int'($urandom % 4);
            if (op != 3) begin
                b = int'($urandom % (MAXB + 2));
                for (int i = 0; i < b; i++) add_resp(1, 0);
                if (b == MAXB + 1) add_resp(int'($urandom % 4), 0);
                else begin
                    r = int'($urandom % 6);
                    if (r < 2)       add_resp(0, 0);
                    else if (r < 4)  add_resp(r, 0);
                    else             add_resp(int'($urandom % 4), r - 3);
                end
            end
            run_xact(op, 1'($urandom % 2));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule